// File: doc/BRIEF.md
# Refresh and Power-Up Sequencer for an Asynchronous DRAM

This block owns the row and column strobes of an asynchronous 4-bit DRAM whenever a refresh is under way. After reset it keeps the strobes high through a long settling delay. It then runs a fixed number of warm-up refresh cycles and only after that reports the memory as usable. From then on a free-running interval timer adds one refresh request per interval to a small saturating backlog. Each request is served only when the access controller grants the strobes.

Every refresh uses the column-strobe-first order. The column strobe drops ahead of the row strobe, so the memory picks the row from its own internal counter and the block keeps no row address. The write enable is held high at all times. All timing limits are given in nanoseconds and turned into clock counts with ceiling rounding against a clock-period parameter. Address multiplexing, data movement and row-address-driven refresh belong to other blocks.

Top module: `cbr_refresh_init`

## Requirements
- R1: While reset is asserted, and at once when it is asserted, ras_n_o, cas_n_o and we_n_o are 1 and mem_ready_o, ref_req_o and ref_busy_o are 0.
- R2: After reset is released, cas_n_o and ras_n_o stay high until cas_n_o first falls, on the (S+1)-th rising clock edge, where S = ceil(STARTUP_NS/CLK_NS).
- R3: Exactly WARMUP_CYCLES refresh cycles (falls of ras_n_o) occur before mem_ready_o rises, with ref_gnt_i held low throughout.
- R4: In every refresh cycle cas_n_o is already low when ras_n_o falls, and ras_n_o falls exactly ceil(CSR_NS/CLK_NS) cycles after cas_n_o fell.
- R5: cas_n_o rises exactly ceil(CHR_NS/CLK_NS) cycles after ras_n_o fell, while ras_n_o is still low.
- R6: ras_n_o stays low for exactly max(ceil(RAS_MIN_NS/CLK_NS), ceil(CHR_NS/CLK_NS)+1) cycles, and never for longer than floor(RAS_MAX_NS/CLK_NS) cycles.
- R7: From a rise of ras_n_o to the next fall of cas_n_o there are at least P cycles, where P is the largest of ceil(RP_NS/CLK_NS), ceil(RPC_NS/CLK_NS) and the cycles needed so that consecutive falls of ras_n_o are at least ceil(RC_NS/CLK_NS) cycles apart; that spacing also holds.
- R8: we_n_o is 1 in every cycle.
- R9: ref_req_o is never high while mem_ready_o is low. Once ready, one refresh request is added every I = ceil(REFRESH_NS/CLK_NS) cycles, the first one I cycles after mem_ready_o rises. With ref_gnt_i held high, consecutive refreshes start exactly I cycles apart.
- R10: Once the block is ready, a refresh starts only on a clock edge where ref_req_o and ref_gnt_i are both high. ref_busy_o is high whenever ras_n_o is low. With ref_gnt_i low, no refresh starts and ref_req_o stays high.
- R11: Deferred requests accumulate up to PEND_MAX and no further. After k intervals without a grant, a grant yields exactly min(k, PEND_MAX) back-to-back refresh cycles before ref_req_o and ref_busy_o both go low.
- R12: Once mem_ready_o is high it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt_i | input | 1 | Access controller is idle and hands the strobes over |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |
| ref_req_o | output | 1 | A refresh is pending and the sequencer is free |
| ref_busy_o | output | 1 | A refresh cycle owns the strobes |
| mem_ready_o | output | 1 | Warm-up finished; normal accesses may begin |

## Verification
The bench uses a 5 ns clock period, STARTUP_NS = 2000, REFRESH_NS = 2000 and PEND_MAX = 3, and keeps the default strobe limits. That gives 400 settling cycles, a 400-cycle request interval and a 40-cycle minimum refresh period. Warm-up, several deferred-request depths and backlog saturation therefore all happen within a few thousand cycles, while every interval is still long enough to drain a full backlog before the next request arrives.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE     = 3'd0,
        SQ_CAS_LEAD = 3'd1,
        SQ_BOTH_LOW = 3'd2,
        SQ_RAS_ONLY = 3'd3,
        SQ_PRECHG   = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_SETTLE = 2'd0,
        PH_WARMUP = 2'd1,
        PH_RUN    = 2'd2
    } phase_e;

    // Nanoseconds to clock cycles, rounded up, never below one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
    parameter int unsigned INTERVAL_CYC = 3125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned CW = cbr_pkg::umax(1, $clog2(INTERVAL_CYC + 1));

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!en_i) begin
            t_d.cnt = CW'(INTERVAL_CYC - 1);
        end else if (t_q.cnt == '0) begin
            t_d.cnt = CW'(INTERVAL_CYC - 1);
        end else begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cnt <= CW'(INTERVAL_CYC - 1);
        end else begin
            t_q <= t_d;
        end
    end

    assign tick_o = en_i && (t_q.cnt == '0);

    // Checker: cycles since enable or since the previous tick.
    logic [CW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (!en_i || tick_o) begin
            gap_q <= '0;
        end else if (gap_q != {CW{1'b1}}) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_tick_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (gap_q == CW'(INTERVAL_CYC - 1)));

endmodule

// File: rtl/cbr_pend_ctr.sv
module cbr_pend_ctr #(
    parameter int unsigned PEND_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add_i,
    input  logic take_i,
    output logic any_o
);
    localparam int unsigned PW = cbr_pkg::umax(1, $clog2(PEND_MAX + 1));

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pend_t;

    pend_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (add_i && !take_i) begin
            if (p_q.cnt != PW'(PEND_MAX)) begin
                p_d.cnt = p_q.cnt + 1'b1;
            end
        end else if (take_i && !add_i) begin
            p_d.cnt = p_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.cnt <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign any_o = (p_q.cnt != '0);

    assert_take_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> any_o);

    assert_sat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (add_i && !take_i && (p_q.cnt == PW'(PEND_MAX))) |=> (p_q.cnt == PW'(PEND_MAX)));

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.cnt <= PW'(PEND_MAX));

endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq #(
    parameter int unsigned CSR_CYC     = 2,
    parameter int unsigned CHR_CYC     = 3,
    parameter int unsigned RAS_CYC     = 20,
    parameter int unsigned RAS_MAX_CYC = 2000,
    parameter int unsigned PRE_CYC     = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic busy_o
);
    import cbr_pkg::*;

    localparam int unsigned TAIL_CYC = RAS_CYC - CHR_CYC;
    localparam int unsigned CNT_TOP  = umax(umax(CSR_CYC, CHR_CYC), umax(TAIL_CYC, PRE_CYC));
    localparam int unsigned CW       = umax(1, $clog2(CNT_TOP + 1));
    localparam int unsigned LW       = umax(1, $clog2(RAS_MAX_CYC + 2));

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          ras_n;
        logic          cas_n;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    s_d.st  = SQ_CAS_LEAD;
                    s_d.cnt = CW'(CSR_CYC - 1);
                end
            end
            SQ_CAS_LEAD: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = SQ_BOTH_LOW;
                    s_d.cnt = CW'(CHR_CYC - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            SQ_BOTH_LOW: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = SQ_RAS_ONLY;
                    s_d.cnt = CW'(TAIL_CYC - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            SQ_RAS_ONLY: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = SQ_PRECHG;
                    s_d.cnt = CW'(PRE_CYC - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            SQ_PRECHG: begin
                if (s_q.cnt == '0) begin
                    s_d.st = SQ_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: begin
                s_d.st  = SQ_IDLE;
                s_d.cnt = '0;
            end
        endcase
        // Strobes are registered copies of the next state's decode.
        s_d.cas_n = !((s_d.st == SQ_CAS_LEAD) || (s_d.st == SQ_BOTH_LOW));
        s_d.ras_n = !((s_d.st == SQ_BOTH_LOW) || (s_d.st == SQ_RAS_ONLY));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= SQ_IDLE;
            s_q.cnt   <= '0;
            s_q.ras_n <= 1'b1;
            s_q.cas_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ras_n_o = s_q.ras_n;
    assign cas_n_o = s_q.cas_n;
    assign busy_o  = (s_q.st != SQ_IDLE);

    // Checker counters for strobe widths.
    logic [LW-1:0] ras_low_q;
    logic [LW-1:0] both_low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_low_q  <= '0;
            both_low_q <= '0;
        end else begin
            if (ras_n_o) ras_low_q <= '0;
            else if (ras_low_q != {LW{1'b1}}) ras_low_q <= ras_low_q + 1'b1;
            if (ras_n_o || cas_n_o) both_low_q <= '0;
            else if (both_low_q != {LW{1'b1}}) both_low_q <= both_low_q + 1'b1;
        end
    end

    assert_cas_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

    assert_cas_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n_o) |-> (!ras_n_o && (both_low_q >= LW'(CHR_CYC))));

    assert_ras_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> (ras_low_q >= LW'(RAS_CYC)));

    assert_ras_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_o |-> (ras_low_q < LW'(RAS_MAX_CYC)));

    assert_busy_covers_ras_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_o |-> busy_o);

endmodule

// File: rtl/cbr_refresh_init.sv
module cbr_refresh_init #(
    parameter int unsigned CLK_NS        = 5,
    parameter int unsigned STARTUP_NS    = 200000,
    parameter int unsigned REFRESH_NS    = 15625,
    parameter int unsigned WARMUP_CYCLES = 8,
    parameter int unsigned PEND_MAX      = 4,
    parameter int unsigned CSR_NS        = 10,
    parameter int unsigned CHR_NS        = 15,
    parameter int unsigned RAS_MIN_NS    = 100,
    parameter int unsigned RAS_MAX_NS    = 10000,
    parameter int unsigned RP_NS         = 60,
    parameter int unsigned RPC_NS        = 10,
    parameter int unsigned RC_NS         = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt_i,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o,
    output logic ref_req_o,
    output logic ref_busy_o,
    output logic mem_ready_o
);
    import cbr_pkg::*;

    localparam int unsigned STARTUP_CYC  = ns_to_cyc(STARTUP_NS, CLK_NS);
    localparam int unsigned INTERVAL_CYC = ns_to_cyc(REFRESH_NS, CLK_NS);
    localparam int unsigned CSR_CYC      = ns_to_cyc(CSR_NS, CLK_NS);
    localparam int unsigned CHR_CYC      = ns_to_cyc(CHR_NS, CLK_NS);
    localparam int unsigned RAS_CYC      = umax(ns_to_cyc(RAS_MIN_NS, CLK_NS), CHR_CYC + 1);
    localparam int unsigned RAS_MAX_CYC  = umax(RAS_MAX_NS / CLK_NS, RAS_CYC + 1);
    localparam int unsigned RP_CYC       = ns_to_cyc(RP_NS, CLK_NS);
    localparam int unsigned RPC_CYC      = ns_to_cyc(RPC_NS, CLK_NS);
    localparam int unsigned RC_CYC       = ns_to_cyc(RC_NS, CLK_NS);
    localparam int unsigned RC_GAP       = (RC_CYC > RAS_CYC + CSR_CYC) ? (RC_CYC - RAS_CYC - CSR_CYC) : 1;
    localparam int unsigned PRE_CYC      = umax(umax(RP_CYC, RPC_CYC), RC_GAP);
    localparam int unsigned SW           = umax(1, $clog2(STARTUP_CYC + 1));
    localparam int unsigned WW           = umax(1, $clog2(WARMUP_CYCLES + 1));

    typedef struct packed {
        phase_e        phase;
        logic [SW-1:0] settle;
        logic [WW-1:0] warm;
        logic          ready;
    } top_t;

    top_t t_d, t_q;

    logic seq_start;
    logic seq_busy;
    logic pend_take;
    logic pend_any;
    logic tick;

    assign ref_req_o = (t_q.phase == PH_RUN) && !seq_busy && pend_any;

    always_comb begin
        t_d       = t_q;
        seq_start = 1'b0;
        pend_take = 1'b0;
        unique case (t_q.phase)
            PH_SETTLE: begin
                if (t_q.settle == '0) begin
                    t_d.phase = PH_WARMUP;
                end else begin
                    t_d.settle = t_q.settle - 1'b1;
                end
            end
            PH_WARMUP: begin
                if (!seq_busy) begin
                    if (t_q.warm == WW'(WARMUP_CYCLES)) begin
                        t_d.phase = PH_RUN;
                        t_d.ready = 1'b1;
                    end else begin
                        seq_start = 1'b1;
                        t_d.warm  = t_q.warm + 1'b1;
                    end
                end
            end
            PH_RUN: begin
                if (ref_req_o && ref_gnt_i) begin
                    seq_start = 1'b1;
                    pend_take = 1'b1;
                end
            end
            default: begin
                t_d.phase = PH_SETTLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.phase  <= PH_SETTLE;
            t_q.settle <= SW'(STARTUP_CYC - 1);
            t_q.warm   <= '0;
            t_q.ready  <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    cbr_interval_timer #(
        .INTERVAL_CYC (INTERVAL_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (t_q.ready),
        .tick_o (tick)
    );

    cbr_pend_ctr #(
        .PEND_MAX (PEND_MAX)
    ) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_i  (tick),
        .take_i (pend_take),
        .any_o  (pend_any)
    );

    cbr_strobe_seq #(
        .CSR_CYC     (CSR_CYC),
        .CHR_CYC     (CHR_CYC),
        .RAS_CYC     (RAS_CYC),
        .RAS_MAX_CYC (RAS_MAX_CYC),
        .PRE_CYC     (PRE_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (seq_start),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .busy_o  (seq_busy)
    );

    assign we_n_o      = 1'b1;
    assign ref_busy_o  = seq_busy;
    assign mem_ready_o = t_q.ready;

    // Checker: row-strobe falls seen before ready.
    logic          ras_prev_q;
    logic [WW:0]   warm_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_prev_q  <= 1'b1;
            warm_seen_q <= '0;
        end else begin
            ras_prev_q <= ras_n_o;
            if (!mem_ready_o && ras_prev_q && !ras_n_o && (warm_seen_q != {(WW+1){1'b1}})) begin
                warm_seen_q <= warm_seen_q + 1'b1;
            end
        end
    end

    assert_settle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.phase == PH_SETTLE) |-> (ras_n_o && cas_n_o));

    assert_warmup_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ready_o) |-> (warm_seen_q == (WW+1)'(WARMUP_CYCLES)));

    assert_req_after_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> mem_ready_o);

    assert_start_handshake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ref_busy_o) && mem_ready_o) |-> $past(ref_req_o && ref_gnt_i));

    assert_ready_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready_o |=> mem_ready_o);

endmodule

// File: tb/tb_cbr_refresh_init.sv
`timescale 1ns/1ps
module tb_cbr_refresh_init;

    localparam int CLK_NS     = 5;
    localparam int STARTUP_NS = 2000;
    localparam int REFRESH_NS = 2000;
    localparam int WARM       = 8;
    localparam int PMAX       = 3;

    function automatic int up_div(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int STARTUP_CYC  = up_div(STARTUP_NS);
    localparam int INTERVAL_CYC = up_div(REFRESH_NS);
    localparam int CSR_CYC      = up_div(10);
    localparam int CHR_CYC      = up_div(15);
    localparam int RAS_CYC      = (up_div(100) > CHR_CYC) ? up_div(100) : CHR_CYC + 1;
    localparam int RC_CYC       = up_div(200);
    localparam int GAP_A        = (up_div(60) > up_div(10)) ? up_div(60) : up_div(10);
    localparam int GAP_B        = (RC_CYC > RAS_CYC + CSR_CYC) ? RC_CYC - RAS_CYC - CSR_CYC : 1;
    localparam int PRE_CYC      = (GAP_A > GAP_B) ? GAP_A : GAP_B;

    localparam int ROWS = 4;
    localparam int DEFER_TICKS [0:ROWS-1] = '{1, 2, 3, 5};
    localparam int EXP_RUNS    [0:ROWS-1] = '{1, 2, 3, 3};

    logic clk = 1'b0;
    logic rst_n;
    logic ref_gnt;
    logic ras_n_o, cas_n_o, we_n_o, ref_req_o, ref_busy_o, mem_ready_o;

    always #2.5 clk = ~clk;

    cbr_refresh_init #(
        .CLK_NS     (CLK_NS),
        .STARTUP_NS (STARTUP_NS),
        .REFRESH_NS (REFRESH_NS),
        .PEND_MAX   (PMAX)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_gnt_i   (ref_gnt),
        .ras_n_o     (ras_n_o),
        .cas_n_o     (cas_n_o),
        .we_n_o      (we_n_o),
        .ref_req_o   (ref_req_o),
        .ref_busy_o  (ref_busy_o),
        .mem_ready_o (mem_ready_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe monitor, samples 2 ns after each rising edge.
    int cyc = 0;
    int t_cf = 0, t_rf = 0, t_rr = 0;
    int ras_falls = 0;
    bit have_rf = 0, have_rr = 0, first_cf = 0;
    bit prev_ras = 1, prev_cas = 1, prev_ready = 0;
    bit we_bad = 0, ready_drop = 0, early_req = 0;

    always @(posedge clk) begin
        #2;
        if (!rst_n) begin
            cyc = 0; have_rf = 0; have_rr = 0; first_cf = 0;
            prev_ras = 1; prev_cas = 1; prev_ready = 0;
        end else begin
            cyc++;
            if (we_n_o !== 1'b1) we_bad = 1;
            if (ref_req_o && !mem_ready_o) early_req = 1;
            if (prev_ready && !mem_ready_o) ready_drop = 1;
            if (prev_cas && !cas_n_o) begin
                if (!first_cf) begin
                    chk(cyc == STARTUP_CYC + 1, "R2 first column strobe", cyc, STARTUP_CYC + 1);
                    first_cf = 1;
                end
                if (have_rr) chk(cyc - t_rr >= PRE_CYC, "R7 precharge", cyc - t_rr, PRE_CYC);
                t_cf = cyc;
            end
            if (prev_ras && !ras_n_o) begin
                chk(!cas_n_o && (cyc - t_cf == CSR_CYC), "R4 column lead", cyc - t_cf, CSR_CYC);
                chk(ref_busy_o == 1'b1, "R10 busy with row strobe", ref_busy_o, 1);
                if (have_rf) chk(cyc - t_rf >= RC_CYC, "R7 cycle spacing", cyc - t_rf, RC_CYC);
                t_rf = cyc; have_rf = 1; ras_falls++;
            end
            if (!prev_cas && cas_n_o)
                chk(!ras_n_o && (cyc - t_rf == CHR_CYC), "R5 column hold", cyc - t_rf, CHR_CYC);
            if (!prev_ras && ras_n_o) begin
                chk(cyc - t_rf == RAS_CYC, "R6 row low width", cyc - t_rf, RAS_CYC);
                t_rr = cyc; have_rr = 1;
            end
            prev_ras = ras_n_o; prev_cas = cas_n_o; prev_ready = mem_ready_o;
        end
    end

    task automatic step();
        @(posedge clk);
        #3;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int t0;
        int f0;
        int ta;
        rst_n   = 1'b0;
        ref_gnt = 1'b0;
        repeat (3) step();

        // R1: idle outputs in reset
        chk(ras_n_o == 1'b1, "R1 ras_n", ras_n_o, 1);
        chk(cas_n_o == 1'b1, "R1 cas_n", cas_n_o, 1);
        chk(we_n_o == 1'b1, "R1 we_n", we_n_o, 1);
        chk(mem_ready_o == 1'b0 && ref_req_o == 1'b0 && ref_busy_o == 1'b0,
            "R1 ready/req/busy", {mem_ready_o, ref_req_o, ref_busy_o}, 0);

        rst_n = 1'b1;
        while (!mem_ready_o) step();
        chk(ras_falls == WARM, "R3 warm-up cycles", ras_falls, WARM);

        t0 = cyc;
        while (!ref_req_o) step();
        chk(cyc - t0 == INTERVAL_CYC, "R9 first request delay", cyc - t0, INTERVAL_CYC);

        // Table: defer k intervals, then grant and count cycles served.
        for (int r = 0; r < ROWS; r++) begin
            if (r > 0) while (!ref_req_o) step();
            f0 = ras_falls;
            repeat ((DEFER_TICKS[r] - 1) * INTERVAL_CYC + INTERVAL_CYC / 2) step();
            chk(ras_falls == f0, "R10 no refresh without grant", ras_falls - f0, 0);
            chk(ref_req_o == 1'b1, "R10 request held", ref_req_o, 1);
            ref_gnt = 1'b1;
            step();
            while (ref_req_o || ref_busy_o) step();
            ref_gnt = 1'b0;
            chk(ras_falls - f0 == EXP_RUNS[r], "R11 backlog served", ras_falls - f0, EXP_RUNS[r]);
        end

        // R9: continuous grant gives one refresh per interval
        ref_gnt = 1'b1;
        f0 = ras_falls;
        while (ras_falls == f0) step();
        ta = t_rf;
        f0 = ras_falls;
        while (ras_falls == f0) step();
        chk(t_rf - ta == INTERVAL_CYC, "R9 refresh period", t_rf - ta, INTERVAL_CYC);

        // R1: reset in the middle of a refresh
        while (ras_n_o) step();
        rst_n = 1'b0;
        ref_gnt = 1'b0;
        #1;
        chk(ras_n_o == 1'b1 && cas_n_o == 1'b1, "R1 strobes on reset", {ras_n_o, cas_n_o}, 3);
        chk(mem_ready_o == 1'b0 && ref_busy_o == 1'b0 && ref_req_o == 1'b0,
            "R1 status on reset", {mem_ready_o, ref_busy_o, ref_req_o}, 0);
        repeat (2) step();
        rst_n = 1'b1;
        repeat (50) step();
        chk(mem_ready_o == 1'b0, "R2 not ready during settle", mem_ready_o, 0);
        chk(cas_n_o == 1'b1 && ras_n_o == 1'b1, "R2 strobes quiet", {cas_n_o, ras_n_o}, 3);
        while (cas_n_o) step();
        step();

        chk(!we_bad, "R8 write enable high", we_bad, 0);
        chk(!early_req, "R9 request before ready", early_req, 0);
        chk(!ready_drop, "R12 ready sticky", ready_drop, 0);
        finish_run();
    end

endmodule